// File: doc/BRIEF.md
# Byte-Lane Steered 8-bit Peripheral Port

This block connects a single 8-bit peripheral register to a 16-bit CPU data bus whose address space is byte-granular. The port answers at two neighbouring I/O addresses, DCh and DDh, so no byte address in its window goes unused. The lowest address bit picks which half of the 16-bit bus is connected to the peripheral for a transfer. An even address uses the upper half of the bus and an odd address uses the lower half. Only one half is ever connected at a time.

Writes are captured on a rising clock edge when the active-low write strobe is low and the address matches. The byte is taken from the selected lane and the other lane is ignored. Reads are registered. On the cycle after a matching read strobe, the stored byte is placed on the selected lane and only that lane's drive enable is raised. The other lane is not enabled and reads as zero. The number of lanes, lane width, address width and base address are parameters. The mapping is big-endian: the lowest address in the window selects the most significant lane.

Top module: `bytelane_port`

## Requirements
- R1: While `rst` is high, at the next clock edge `periph_q` becomes 00h, `bus_rd_oe` becomes 2'b00 and `bus_rdata` becomes 0000h.
- R2: A write to DCh (`io_wr_n` low, address bit 0 = 0) stores `bus_wdata[15:8]` into `periph_q` at that clock edge. Bits 7..0 of the bus are discarded.
- R3: A write to DDh (address bit 0 = 1) stores `bus_wdata[7:0]` into `periph_q` at that clock edge. Bits 15..8 of the bus are discarded.
- R4: A write strobe at any address other than DCh or DDh (for example DEh, DBh or 5Ch) leaves `periph_q` unchanged.
- R5: With `io_wr_n` high, a matching address and any bus data leave `periph_q` unchanged.
- R6: A read strobe (`io_rd_n` low) at DCh gives, one clock later, `bus_rdata[15:8]` = stored byte, `bus_rdata[7:0]` = 00h and `bus_rd_oe` = 2'b10 (bit 1 = upper lane).
- R7: A read strobe at DDh gives, one clock later, `bus_rdata[7:0]` = stored byte, `bus_rdata[15:8]` = 00h and `bus_rd_oe` = 2'b01 (bit 0 = lower lane).
- R8: At most one bit of `bus_rd_oe` is set at any time. In a cycle after which no matching read strobe was sampled, `bus_rd_oe` is 2'b00 and `bus_rdata` is 0000h.
- R9: When a read and a write to the port are sampled at the same edge, the read returns the byte held before that write, and `periph_q` takes the new byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | Byte address of the I/O transfer |
| io_wr_n | input | 1 | Active-low I/O write strobe |
| io_rd_n | input | 1 | Active-low I/O read strobe |
| bus_wdata | input | 16 | CPU write data, both lanes |
| bus_rdata | output | 16 | Registered read data; the unselected lane is zero |
| bus_rd_oe | output | 2 | Per-lane drive enable (bit 1 upper, bit 0 lower) |
| periph_q | output | 8 | Stored peripheral byte |

## Verification
A write appears on `periph_q` right after the edge that samples the strobe. A read result and its lane enable are valid for exactly the one cycle after the sampling edge. The bench drives inputs on falling edges. It applies each strobe for one cycle and samples on the next falling edge, so the registered result is read half a period after the edge that made it. A behavioural model updated on every rising edge is compared with all three outputs on every falling edge, so a late or extra lane enable is caught in the cycle where it appears.

// File: rtl/bytelane_port_pkg.sv
package bytelane_port_pkg;

  // Access kinds decoded from the two strobes for one cycle
  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_READ  = 2'b10,
    ACC_BOTH  = 2'b11
  } access_e;

  // Big-endian lane mapping: byte offset 0 selects the most significant lane
  function automatic int unsigned lane_for_offset(input int unsigned offset,
                                                  input int unsigned lanes);
    return lanes - 1 - offset;
  endfunction

endpackage

// File: rtl/blp_addr_decode.sv
module blp_addr_decode
  import bytelane_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2,
  parameter logic [ADDR_W-1:0] BASE = 8'hDC,
  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr_n,
  input  logic              io_rd_n,
  output access_e           access,
  output logic [LANES-1:0]  lane_oh
);

  logic win_hit;

  // Full decode of every address bit above the byte offset
  assign win_hit = (io_addr[ADDR_W-1:SEL_W] == BASE[ADDR_W-1:SEL_W]);

  always_comb begin
    access = ACC_NONE;
    if (win_hit) begin
      unique case ({!io_rd_n, !io_wr_n})
        2'b01:   access = ACC_WRITE;
        2'b10:   access = ACC_READ;
        2'b11:   access = ACC_BOTH;
        default: access = ACC_NONE;
      endcase
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned OFFS = lane_for_offset(i, LANES);
    assign lane_oh[i] = (io_addr[SEL_W-1:0] == SEL_W'(OFFS));
  end

endmodule

// File: rtl/blp_lane_select.sv
module blp_lane_select #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [LANES-1:0]  lane_oh,
  output logic [LANE_W-1:0] lane_byte
);

  // AND-OR steering: exactly one lane reaches the peripheral
  always_comb begin
    lane_byte = '0;
    for (int i = 0; i < LANES; i++) begin
      lane_byte = lane_byte | (bus_wdata[i*LANE_W +: LANE_W] & {LANE_W{lane_oh[i]}});
    end
  end

endmodule

// File: rtl/blp_store.sv
module blp_store #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [LANE_W-1:0] cap_byte,
  output logic [LANE_W-1:0] store_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else if (cap_en) begin
      store_q <= cap_byte;
    end
  end

endmodule

// File: rtl/blp_lane_place.sv
module blp_lane_place #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [LANES-1:0]  lane_oh,
  input  logic [LANE_W-1:0] rd_byte,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [LANES-1:0]  bus_rd_oe
);

  for (genvar i = 0; i < LANES; i++) begin : g_place
    always_ff @(posedge clk) begin
      if (rst) begin
        bus_rdata[i*LANE_W +: LANE_W] <= '0;
        bus_rd_oe[i]                  <= 1'b0;
      end else begin
        bus_rdata[i*LANE_W +: LANE_W] <= (rd_en && lane_oh[i]) ? rd_byte : '0;
        bus_rd_oe[i]                  <= rd_en && lane_oh[i];
      end
    end
  end

endmodule

// File: rtl/bytelane_port.sv
module bytelane_port
  import bytelane_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'hDC,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr_n,
  input  logic              io_rd_n,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [LANES-1:0]  bus_rd_oe,
  output logic [LANE_W-1:0] periph_q
);

  access_e           access;
  logic [LANES-1:0]  lane_oh;
  logic [LANE_W-1:0] wr_byte;
  logic              wr_en;
  logic              rd_en;

  blp_addr_decode #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .BASE   (BASE)
  ) u_dec (
    .io_addr (io_addr),
    .io_wr_n (io_wr_n),
    .io_rd_n (io_rd_n),
    .access  (access),
    .lane_oh (lane_oh)
  );

  assign wr_en = (access == ACC_WRITE) || (access == ACC_BOTH);
  assign rd_en = (access == ACC_READ)  || (access == ACC_BOTH);

  blp_lane_select #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_sel (
    .bus_wdata (bus_wdata),
    .lane_oh   (lane_oh),
    .lane_byte (wr_byte)
  );

  blp_store #(
    .LANE_W (LANE_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (wr_en),
    .cap_byte (wr_byte),
    .store_q  (periph_q)
  );

  // Read samples the byte held before this edge, so read-with-write gives old data
  blp_lane_place #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_place (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .lane_oh   (lane_oh),
    .rd_byte   (periph_q),
    .bus_rdata (bus_rdata),
    .bus_rd_oe (bus_rd_oe)
  );

endmodule

// File: rtl/bytelane_port_chk.sv
module bytelane_port_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'hDC,
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned SEL_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr_n,
  input logic              io_rd_n,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [LANES-1:0]  bus_rd_oe,
  input logic [LANE_W-1:0] periph_q
);

  logic in_win, first_off, last_off, wr_hit, rd_hit;

  assign in_win    = (io_addr[ADDR_W-1:SEL_W] == BASE[ADDR_W-1:SEL_W]);
  assign first_off = (io_addr[SEL_W-1:0] == '0);
  assign last_off  = (io_addr[SEL_W-1:0] == SEL_W'(LANES-1));
  assign wr_hit    = in_win && !io_wr_n;
  assign rd_hit    = in_win && !io_rd_n;

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (periph_q == '0 && bus_rd_oe == '0 && bus_rdata == '0));

  // R2
  p_even_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && first_off) |=> periph_q == $past(bus_wdata[DATA_W-1 -: LANE_W]));

  // R3
  p_odd_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && last_off) |=> periph_q == $past(bus_wdata[LANE_W-1:0]));

  // R4 and R5
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(periph_q));

  // R6 and R9
  p_even_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && first_off) |=>
      (bus_rd_oe[LANES-1] && bus_rdata[DATA_W-1 -: LANE_W] == $past(periph_q) &&
       bus_rdata[DATA_W-LANE_W-1:0] == '0));

  // R7 and R9
  p_odd_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && last_off) |=>
      (bus_rd_oe[0] && bus_rdata[LANE_W-1:0] == $past(periph_q) &&
       bus_rdata[DATA_W-1:LANE_W] == '0));

  // R8
  p_one_lane_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_rd_oe));

  // R8
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (bus_rd_oe == '0 && bus_rdata == '0));

endmodule

bind bytelane_port bytelane_port_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES),
  .LANE_W (LANE_W),
  .BASE   (BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .io_addr   (io_addr),
  .io_wr_n   (io_wr_n),
  .io_rd_n   (io_rd_n),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rd_oe (bus_rd_oe),
  .periph_q  (periph_q)
);

// File: tb/bytelane_port_test.sv
`timescale 1ns/1ps
module bytelane_port_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  io_addr = 8'h00;
  logic        io_wr_n = 1'b1;
  logic        io_rd_n = 1'b1;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic [1:0]  bus_rd_oe;
  logic [7:0]  periph_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int m_reg = 0;
  int m_rdata = 0;
  int m_oe = 0;

  always #5 clk = ~clk;

  bytelane_port uut (
    .clk       (clk),
    .rst       (rst),
    .io_addr   (io_addr),
    .io_wr_n   (io_wr_n),
    .io_rd_n   (io_rd_n),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rd_oe (bus_rd_oe),
    .periph_q  (periph_q)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Model: port lives at DCh (upper lane) and DDh (lower lane)
  always @(posedge clk) begin
    int old;
    if (rst) begin
      m_reg = 0; m_rdata = 0; m_oe = 0;
    end else begin
      old = m_reg;
      m_rdata = 0; m_oe = 0;
      if (!io_rd_n && io_addr == 8'hDC) begin m_rdata = old * 256; m_oe = 2; end
      if (!io_rd_n && io_addr == 8'hDD) begin m_rdata = old;       m_oe = 1; end
      if (!io_wr_n && io_addr == 8'hDC) m_reg = int'(bus_wdata) / 256;
      if (!io_wr_n && io_addr == 8'hDD) m_reg = int'(bus_wdata) % 256;
    end
  end

  // Every-cycle comparison, half a period after the edge
  always @(negedge clk) begin
    if (!done) begin
      check("R2", "model periph_q", int'(periph_q), m_reg);
      check("R8", "model bus_rd_oe", int'(bus_rd_oe), m_oe);
      check("R6", "model bus_rdata", int'(bus_rdata), m_rdata);
    end
  end

  task automatic idle();
    @(negedge clk);
    io_wr_n = 1'b1; io_rd_n = 1'b1;
  endtask

  task automatic drive(input logic [7:0] a, input logic [15:0] d, input logic wr, input logic rd);
    @(negedge clk);
    io_addr = a; bus_wdata = d; io_wr_n = !wr; io_rd_n = !rd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "periph_q in reset", int'(periph_q), 0);
    check("R1", "bus_rd_oe in reset", int'(bus_rd_oe), 0);
    check("R1", "bus_rdata in reset", int'(bus_rdata), 0);
    rst = 1'b0;

    // R2: even address takes upper lane, lower discarded
    drive(8'hDC, 16'hA55A, 1, 0); idle();
    check("R2", "periph_q after DCh write", int'(periph_q), 8'hA5);

    // R6: even read places on upper lane
    drive(8'hDC, 16'h0000, 0, 1); idle();
    check("R6", "bus_rdata DCh read", int'(bus_rdata), 16'hA500);
    check("R6", "bus_rd_oe DCh read", int'(bus_rd_oe), 2'b10);
    @(negedge clk);
    check("R8", "bus_rd_oe after read", int'(bus_rd_oe), 0);

    // R3: odd address takes lower lane
    drive(8'hDD, 16'h12C3, 1, 0); idle();
    check("R3", "periph_q after DDh write", int'(periph_q), 8'hC3);

    // R7: odd read places on lower lane
    drive(8'hDD, 16'hFFFF, 0, 1); idle();
    check("R7", "bus_rdata DDh read", int'(bus_rdata), 16'h00C3);
    check("R7", "bus_rd_oe DDh read", int'(bus_rd_oe), 2'b01);

    // R4: writes outside the window
    drive(8'hDE, 16'hFFFF, 1, 0);
    drive(8'hDB, 16'h7777, 1, 0);
    drive(8'h5C, 16'h9999, 1, 0);
    drive(8'h5D, 16'h9999, 1, 0); idle();
    check("R4", "periph_q after foreign writes", int'(periph_q), 8'hC3);

    // R5: matching address, strobe high
    drive(8'hDC, 16'h3C3C, 0, 0);
    drive(8'hDD, 16'h3C3C, 0, 0); idle();
    check("R5", "periph_q without strobe", int'(periph_q), 8'hC3);

    // R8: foreign read leaves both lanes off
    drive(8'hDE, 16'h0000, 0, 1); idle();
    check("R8", "bus_rd_oe foreign read", int'(bus_rd_oe), 0);
    check("R8", "bus_rdata foreign read", int'(bus_rdata), 0);

    // R9: read and write at the same edge
    drive(8'hDC, 16'h6600, 1, 1); idle();
    check("R9", "bus_rdata old byte", int'(bus_rdata), 16'hC300);
    check("R9", "periph_q new byte", int'(periph_q), 8'h66);

    // Mixed traffic compared against the model every cycle
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      case ($urandom_range(0, 4))
        0: a = 8'hDC; 1: a = 8'hDD; 2: a = 8'hDE; 3: a = 8'h5D; default: a = 8'hDC;
      endcase
      drive(a, 16'($urandom), 1'($urandom), 1'($urandom));
    end
    idle();

    // R1: reset after traffic clears the register
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1", "periph_q after late reset", int'(periph_q), 0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule